// File: doc/BRIEF.md
# Per-Processor Private Interrupt State Bank

This block keeps the interrupt state of one processor for its 32 private interrupt sources. Sources 0 to 15 are raised by software and sources 16 to 31 by local peripherals. For each source it holds an enable bit, a pending bit, an active bit, a group bit and an 8-bit priority. It also holds two 32-bit configuration words and a pair of per-group enable flags. Software reaches all of this through one word-aligned 32-bit register port. Hardware raises and drops pending bits through per-source assert and deassert vectors.

The bank drives two level outputs, a normal request and a fast request. A source is forwarded when it is pending, enabled and not already active. Forwarded sources in group 1 drive the normal request, and only while the group-1 flag is on. Forwarded sources in group 0 drive the fast request, and only while the group-0 flag is on. Priority values are stored and read back, but they play no part in choosing what is forwarded.

Top module: `pirq_bank`

## Requirements
- R1: A synchronous active-low reset clears every enable, pending, active and group bit, all priorities, both configuration words and both group flags, and drives both request outputs low. Every register then reads as zero.
- R2: Enable, pending and active each have a set register and a clear register. The set registers are at byte offsets 0x04, 0x0C and 0x14, and the clear registers are at 0x08, 0x10 and 0x18. A 1 in the written word sets the matching bit (set register) or clears it (clear register). A 0 bit leaves that bit unchanged.
- R3: A read of either register of a set/clear pair returns the full 32-bit state vector, with bit n belonging to source n.
- R4: A write to the group register at offset 0x00 replaces the whole group vector with the written word. Reads return that vector.
- R5: The normal request `irq_out` is high when at least one source is pending, enabled, not active and has group bit 1, and the group-1 flag is on.
- R6: The fast request `fiq_out` is high when at least one source is pending, enabled, not active and has group bit 0, and the group-0 flag is on.
- R7: An active source is never forwarded. When no source is forwarded, both request outputs are low.
- R8: Both request outputs are registered. They reflect the state as it stood after the previous clock edge, so a state change shows on the outputs one clock later.
- R9: Priorities occupy eight word registers at offsets 0x40 to 0x5C. The word at 0x40 + 4k holds sources 4k to 4k+3, with source 4k in bits 7:0 and source 4k+3 in bits 31:24. A write replaces all four bytes.
- R10: `line_set[n]` sets pending bit n and `line_clr[n]` clears it. Line inputs act after any register write in the same cycle. When both line inputs are high for one source, the clear wins.
- R11: The configuration words at 0x1C and 0x20 are plain read/write registers. The group-flag register at 0x24 holds the group-0 enable in bit 0 and the group-1 enable in bit 1, and reads back those two bits with zeros above.
- R12: Every other word offset reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational, zero when no read is requested |
| line_set | input | 32 | Per-source pending assert |
| line_clr | input | 32 | Per-source pending deassert |
| irq_out | output | 1 | Normal interrupt request (group 1) |
| fiq_out | output | 1 | Fast interrupt request (group 0) |

## Verification
The bench builds the bank with its default parameters: 32 sources, 8-bit priorities and a 7-bit byte offset. With these values the whole 32-word offset space is small enough to read in full. The reset sweep therefore covers every mapped and unmapped word, and the random phase can reach any offset, including the unmapped gaps between and after the register groups. At this width the bench also compares both request outputs against a behavioural model on every clock. This covers the group split, the exclusion of active sources, and the case where a line clear and a register set hit the same source in one cycle.

// File: rtl/pirq_pkg.sv
// Package: shared constants and the write-strobe bundle of the private
// interrupt bank. Assumes 32-bit data words and a word-aligned register map.
package pirq_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PRIO_W     = 8;
    localparam int unsigned PRIO_IDX_W = 3;

    // Word indices (byte offset / 4) of the mapped registers.
    localparam int unsigned WI_GROUP  = 0;
    localparam int unsigned WI_EN_SET = 1;
    localparam int unsigned WI_EN_CLR = 2;
    localparam int unsigned WI_PD_SET = 3;
    localparam int unsigned WI_PD_CLR = 4;
    localparam int unsigned WI_AC_SET = 5;
    localparam int unsigned WI_AC_CLR = 6;
    localparam int unsigned WI_CFG0   = 7;
    localparam int unsigned WI_CFG1   = 8;
    localparam int unsigned WI_GFLAG  = 9;
    localparam int unsigned WI_PRIO   = 16;

    typedef struct packed {
        logic                  grp_wr;
        logic                  en_set;
        logic                  en_clr;
        logic                  pd_set;
        logic                  pd_clr;
        logic                  ac_set;
        logic                  ac_clr;
        logic                  cfg0_wr;
        logic                  cfg1_wr;
        logic                  gflag_wr;
        logic                  prio_wr;
        logic [PRIO_IDX_W-1:0] prio_idx;
    } wr_strobe_t;
endpackage

// File: rtl/pirq_regdec.sv
// Module: turns a register request into one-hot write strobes and a word
// index. Assumes byte offsets with bits 1:0 ignored. Unmapped offsets raise
// no strobe.
module pirq_regdec
    import pirq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned PRIO_WORDS = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-3:0] word_idx,
    output logic              prio_hit,
    output wr_strobe_t        st
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic wr;
    assign word_idx = req_addr[ADDR_W-1:2];
    assign wr       = req_valid && req_write;

    // Purpose: flag offsets that fall inside the priority window.
    always_comb begin
        prio_hit = ({1'b0, word_idx} >= (IDX_W+1)'(WI_PRIO)) &&
                   ({1'b0, word_idx} <  (IDX_W+1)'(WI_PRIO + PRIO_WORDS));
    end

    // Purpose: raise the write strobe of the addressed register.
    always_comb begin
        st          = '0;
        st.prio_idx = PRIO_IDX_W'(word_idx - IDX_W'(WI_PRIO));
        if (wr) begin
            st.grp_wr   = (word_idx == IDX_W'(WI_GROUP));
            st.en_set   = (word_idx == IDX_W'(WI_EN_SET));
            st.en_clr   = (word_idx == IDX_W'(WI_EN_CLR));
            st.pd_set   = (word_idx == IDX_W'(WI_PD_SET));
            st.pd_clr   = (word_idx == IDX_W'(WI_PD_CLR));
            st.ac_set   = (word_idx == IDX_W'(WI_AC_SET));
            st.ac_clr   = (word_idx == IDX_W'(WI_AC_CLR));
            st.cfg0_wr  = (word_idx == IDX_W'(WI_CFG0));
            st.cfg1_wr  = (word_idx == IDX_W'(WI_CFG1));
            st.gflag_wr = (word_idx == IDX_W'(WI_GFLAG));
            st.prio_wr  = prio_hit;
        end
    end
endmodule

// File: rtl/pirq_setclr_vec.sv
// Module: a state vector updated by set and clear masks. When both masks
// carry the same bit, the clear wins. Assumes the caller has already
// folded any ordering between request sources into the two masks.
module pirq_setclr_vec #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    // Purpose: apply set then clear to the stored vector.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_mask) & ~clr_mask;
    end

    // R2: requested set bits are present one clock later.
    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_mask & ~clr_mask)) |=>
        ((q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

    // R2: requested clear bits are gone one clock later.
    assert_clr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((q & $past(clr_mask)) == '0));
endmodule

// File: rtl/pirq_prio_store.sv
// Module: per-source priority bytes, packed four to a word. The lowest
// source number sits in the low byte. A write replaces a whole word.
// Assumes N_IRQ is a multiple of four.
module pirq_prio_store
    import pirq_pkg::*;
#(
    parameter int unsigned N_IRQ = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PRIO_IDX_W-1:0] idx,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rd_word
);
    localparam int unsigned PER_WORD = WORD_W / PRIO_W;
    localparam int unsigned N_WORDS  = N_IRQ / PER_WORD;

    logic [N_WORDS-1:0][WORD_W-1:0] words;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        for (genvar b = 0; b < PER_WORD; b++) begin : g_byte
            // Purpose: hold the priority of source w*PER_WORD+b.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[w][b*PRIO_W +: PRIO_W] <= '0;
                else if (wr_en && idx == PRIO_IDX_W'(w))
                    words[w][b*PRIO_W +: PRIO_W] <= wdata[b*PRIO_W +: PRIO_W];
            end
        end
    end

    assign rd_word = words[idx];

    // R9: a written word reads back unchanged on the next clock.
    assert_prio_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (words[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/pirq_fwd.sv
// Module: forwarding logic. It masks pending by enabled and not active,
// splits the result by group and gates each half with its group flag.
// Outputs are registered, so they follow the state with one clock of lag.
module pirq_fwd #(
    parameter int unsigned N_IRQ = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0] en,
    input  logic [N_IRQ-1:0] act,
    input  logic [N_IRQ-1:0] grp,
    input  logic             g0_on,
    input  logic             g1_on,
    output logic             irq_q,
    output logic             fiq_q
);
    logic [N_IRQ-1:0] fwd;

    // Purpose: sources eligible to raise a request.
    always_comb fwd = pend & en & ~act;

    // Purpose: register both request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= (|(fwd & grp))  && g1_on;
            fiq_q <= (|(fwd & ~grp)) && g0_on;
        end
    end

    // R7: nothing forwarded -> both lines low next clock.
    assert_quiet_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd == '0) |=> (!irq_q && !fiq_q));
    // R5: normal request only with the group-1 flag on a clock earlier.
    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(g1_on));
    // R6: fast request only with the group-0 flag on a clock earlier.
    assert_fiq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_q |-> $past(g0_on));
    // R7: a fully active bank never requests.
    assert_active_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '1) |=> (!irq_q && !fiq_q));
endmodule

// File: rtl/pirq_bank.sv
// Module: top of the per-processor private interrupt bank. It holds the
// group, configuration and flag registers, and wires the decoder, the three
// set/clear vectors, the priority store and the forwarding logic together.
// Assumes single-cycle register requests with combinational read data.
module pirq_bank
    import pirq_pkg::*;
#(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    input  logic [31:0]       line_set,
    input  logic [31:0]       line_clr,
    output logic              irq_out,
    output logic              fiq_out
);
    localparam int unsigned IDX_W      = ADDR_W - 2;
    localparam int unsigned PRIO_WORDS = N_IRQ * PRIO_W / WORD_W;

    wr_strobe_t       st;
    logic [IDX_W-1:0] word_idx;
    logic             prio_hit;
    logic [N_IRQ-1:0] en_q, pd_q, ac_q, grp_q;
    logic [31:0]      cfg0_q, cfg1_q, prio_word;
    logic [1:0]       gflag_q;
    logic [N_IRQ-1:0] pd_set_m, pd_clr_m;

    pirq_regdec #(.ADDR_W(ADDR_W), .PRIO_WORDS(PRIO_WORDS)) u_dec (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .word_idx(word_idx), .prio_hit(prio_hit), .st(st)
    );

    pirq_setclr_vec #(.W(N_IRQ)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_mask(st.en_set ? req_wdata : '0),
        .clr_mask(st.en_clr ? req_wdata : '0),
        .q(en_q)
    );

    pirq_setclr_vec #(.W(N_IRQ)) u_ac (
        .clk(clk), .rst_n(rst_n),
        .set_mask(st.ac_set ? req_wdata : '0),
        .clr_mask(st.ac_clr ? req_wdata : '0),
        .q(ac_q)
    );

    // Purpose: fold register ops and line inputs so that lines act last
    // and a line clear beats a line set.
    always_comb begin
        pd_set_m = (st.pd_set ? req_wdata : '0) | line_set;
        pd_clr_m = ((st.pd_clr ? req_wdata : '0) & ~line_set) | line_clr;
    end

    pirq_setclr_vec #(.W(N_IRQ)) u_pd (
        .clk(clk), .rst_n(rst_n),
        .set_mask(pd_set_m), .clr_mask(pd_clr_m), .q(pd_q)
    );

    pirq_prio_store #(.N_IRQ(N_IRQ)) u_prio (
        .clk(clk), .rst_n(rst_n), .wr_en(st.prio_wr), .idx(st.prio_idx),
        .wdata(req_wdata), .rd_word(prio_word)
    );

    // Purpose: plain registers written whole (group, configs, flags).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= '0;
            cfg0_q  <= '0;
            cfg1_q  <= '0;
            gflag_q <= '0;
        end else begin
            if (st.grp_wr)   grp_q   <= req_wdata;
            if (st.cfg0_wr)  cfg0_q  <= req_wdata;
            if (st.cfg1_wr)  cfg1_q  <= req_wdata;
            if (st.gflag_wr) gflag_q <= req_wdata[1:0];
        end
    end

    pirq_fwd #(.N_IRQ(N_IRQ)) u_fwd (
        .clk(clk), .rst_n(rst_n), .pend(pd_q), .en(en_q), .act(ac_q),
        .grp(grp_q), .g0_on(gflag_q[0]), .g1_on(gflag_q[1]),
        .irq_q(irq_out), .fiq_q(fiq_out)
    );

    // Purpose: read multiplexer; unmapped offsets and idle cycles read zero.
    always_comb begin
        rd_data = '0;
        if (req_valid && !req_write) begin
            if (prio_hit) rd_data = prio_word;
            else begin
                case (word_idx)
                    IDX_W'(WI_GROUP):                   rd_data = grp_q;
                    IDX_W'(WI_EN_SET), IDX_W'(WI_EN_CLR): rd_data = en_q;
                    IDX_W'(WI_PD_SET), IDX_W'(WI_PD_CLR): rd_data = pd_q;
                    IDX_W'(WI_AC_SET), IDX_W'(WI_AC_CLR): rd_data = ac_q;
                    IDX_W'(WI_CFG0):                    rd_data = cfg0_q;
                    IDX_W'(WI_CFG1):                    rd_data = cfg1_q;
                    IDX_W'(WI_GFLAG):                   rd_data = {30'd0, gflag_q};
                    default:                            rd_data = '0;
                endcase
            end
        end
    end

    // R4: a group write replaces the vector rather than merging.
    assert_group_replace_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st.grp_wr |=> (grp_q == $past(req_wdata)));
    // R10: a line clear leaves the pending bit low next clock.
    assert_line_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_clr) |=> ((pd_q & $past(line_clr)) == '0));
    // R11: configuration word 0 takes the written value.
    assert_cfg0_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st.cfg0_wr |=> (cfg0_q == $past(req_wdata)));
endmodule

// File: tb/tb_pirq_bank.sv
module tb_pirq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0, rd_data, line_set = '0, line_clr = '0;
    logic        irq_out, fiq_out;

    int n_vec = 0, n_bad = 0, cycles = 0;
    bit checking = 0, r1_phase = 0;

    always #4 clk = ~clk; // 125 MHz

    pirq_bank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .line_set(line_set), .line_clr(line_clr),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    // Behavioural reference model, updated on each rising edge.
    logic [31:0] m_en, m_pd, m_ac, m_grp, m_c0, m_c1;
    logic [1:0]  m_gf;
    logic [7:0]  m_pr [32];
    logic        m_irq, m_fiq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pd = 0; m_ac = 0; m_grp = 0; m_c0 = 0; m_c1 = 0;
            m_gf = 0; m_irq = 0; m_fiq = 0;
            foreach (m_pr[i]) m_pr[i] = 0;
        end else begin
            m_irq = ((m_pd & m_en & ~m_ac & m_grp) != 0) && m_gf[1];
            m_fiq = ((m_pd & m_en & ~m_ac & ~m_grp) != 0) && m_gf[0];
            if (req_valid && req_write) begin
                int w;
                w = int'(req_addr[6:2]);
                case (w)
                    0: m_grp = req_wdata;
                    1: m_en = m_en | req_wdata;
                    2: m_en = m_en & ~req_wdata;
                    3: m_pd = m_pd | req_wdata;
                    4: m_pd = m_pd & ~req_wdata;
                    5: m_ac = m_ac | req_wdata;
                    6: m_ac = m_ac & ~req_wdata;
                    7: m_c0 = req_wdata;
                    8: m_c1 = req_wdata;
                    9: m_gf = req_wdata[1:0];
                    default:
                        if (w >= 16 && w < 24)
                            for (int b = 0; b < 4; b++)
                                m_pr[(w-16)*4+b] = req_wdata[b*8 +: 8];
                endcase
            end
            m_pd = (m_pd | line_set) & ~line_clr; // R10: lines after bus, clear wins
        end
    end

    function automatic logic [31:0] mread(int w);
        case (w)
            0: return m_grp;
            1, 2: return m_en;
            3, 4: return m_pd;
            5, 6: return m_ac;
            7: return m_c0;
            8: return m_c1;
            9: return {30'd0, m_gf};
            default:
                if (w >= 16 && w < 24)
                    return {m_pr[(w-16)*4+3], m_pr[(w-16)*4+2],
                            m_pr[(w-16)*4+1], m_pr[(w-16)*4]};
                else return 0;
        endcase
    endfunction

    function automatic string tagfor(int w);
        if (r1_phase) return "R1";
        if (w == 0) return "R4";
        if (w >= 1 && w <= 6) return "R3";
        if (w >= 7 && w <= 9) return "R11";
        if (w >= 16 && w < 24) return "R9";
        return "R12";
    endfunction

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            n_vec++;
            if (irq_out !== m_irq) begin // R5, R8
                n_bad++;
                $display("FAIL R5 irq_out actual=%0b expected=%0b t=%0t", irq_out, m_irq, $time);
            end
            n_vec++;
            if (fiq_out !== m_fiq) begin // R6, R7, R8
                n_bad++;
                $display("FAIL R6 fiq_out actual=%0b expected=%0b t=%0t", fiq_out, m_fiq, $time);
            end
            if (req_valid && !req_write) begin
                n_vec++;
                if (rd_data !== mread(int'(req_addr[6:2]))) begin
                    n_bad++;
                    $display("FAIL %s read @%0h actual=%h expected=%h", tagfor(int'(req_addr[6:2])),
                             req_addr, rd_data, mread(int'(req_addr[6:2])));
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=%0d expected<=20000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask
    task automatic idle(int n);
        req_valid = 0; req_write = 0; line_set = 0; line_clr = 0;
        repeat (n) cyc();
    endtask
    task automatic wr(int a, logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = 7'(a); req_wdata = d;
        cyc(); req_valid = 0; req_write = 0;
    endtask
    task automatic rd(int a);
        req_valid = 1; req_write = 0; req_addr = 7'(a);
        cyc(); req_valid = 0;
    endtask
    task automatic lines(logic [31:0] s, logic [31:0] c);
        line_set = s; line_clr = c;
        cyc(); line_set = 0; line_clr = 0;
    endtask

    initial begin
        cyc(); checking = 1;
        repeat (2) cyc();
        rst_n = 1;
        // R1: every word reads zero after reset, outputs low.
        r1_phase = 1;
        for (int w = 0; w < 32; w++) rd(w*4);
        r1_phase = 0;
        // R11: both group flags on; R2: enable sources 4..7.
        wr(32'h24, 32'h3);
        wr(32'h04, 32'h0000_00F0);
        rd(32'h08);                    // R3 via clear register
        // R10: line assert of source 4 (group 0) -> fast request (R6).
        lines(32'h10, 32'h0);
        idle(2);
        wr(32'h00, 32'h10);            // R5: move to group 1
        idle(2);
        wr(32'h00, 32'h20);            // R4: replace, not merge
        rd(32'h00);
        idle(1);
        wr(32'h14, 32'h10);            // R7: active masks it
        idle(2); rd(32'h18);
        wr(32'h18, 32'h10);            // R2 clear active
        idle(2);
        wr(32'h24, 32'h2);             // R6: group-0 flag off
        idle(2);
        lines(32'h20, 32'h20);         // R10: clear wins
        rd(32'h0C);
        req_valid = 1; req_write = 1; req_addr = 7'h0C; req_wdata = 32'h40;
        line_clr = 32'h40; cyc();      // R10: line clear after bus set
        idle(1); rd(32'h10);
        wr(32'h10, 32'h0);             // R2: zero bits do nothing
        rd(32'h0C);
        wr(32'h10, 32'hFFFF_FFFF);
        idle(2);
        // R9: priority words.
        for (int k = 0; k < 8; k++) wr(32'h40 + k*4, 32'h0403_0201 + k*32'h1010_1010);
        for (int k = 0; k < 8; k++) rd(32'h40 + k*4);
        wr(32'h1C, 32'hDEAD_BEEF); wr(32'h20, 32'h1234_5678); // R11
        rd(32'h1C); rd(32'h20); rd(32'h24);
        // R12: unmapped writes ignored.
        wr(32'h28, 32'hFFFF_FFFF); wr(32'h3C, 32'hFFFF_FFFF);
        wr(32'h60, 32'hFFFF_FFFF); wr(32'h7C, 32'hFFFF_FFFF);
        for (int w = 0; w < 32; w++) rd(w*4);
        // Mixed random phase.
        for (int i = 0; i < 1500; i++) begin
            req_valid = ($urandom % 4) != 0;
            req_write = $urandom % 2;
            req_addr  = 7'(($urandom % 32) * 4);
            req_wdata = $urandom;
            line_set  = $urandom & $urandom & $urandom;
            line_clr  = $urandom & $urandom & $urandom & $urandom;
            cyc();
        end
        idle(3);
        checking = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule